// File: doc/BRIEF.md
# Vertical Gate Timing Generator for a Line-Scanned TFT Panel

This block produces the vertical drive set for a 480-line active-matrix panel. Each horizontal line is announced by a one-cycle line strobe. From that strobe a phase counter runs, and every vertical pulse is decoded from it at a fixed number of system-clock ticks. The pulses are: the vertical shift clock, the gate-enable window, the precharge window and the uniformity clear window. The shift clock changes level once per line, and the panel treats both of its edges as shift events. A field is therefore 480 line strobes, which gives a shift clock of roughly 15.7 kHz at normal line rates.

The enable window opens shortly after each shift-clock edge. The precharge and clear windows sit before the next edge, and the clear window ends on that edge. A frame strobe arms the start pulse. The start pulse then covers the whole next line, so it is set up well before that line's shift-clock edge and held beyond it. The scan-direction level is captured on that same line and held for the rest of the field. All offsets are given in nanoseconds and converted to ticks of the system clock. The default values assume a 20 ns clock.

Line strobes must be at least `VCK_DLY_NS + ENB_DLY_NS + ENB_W_NS` plus two clocks apart. `VCK_DLY_NS` must be no smaller than the clear width, and no smaller than the sum of the precharge gap and the precharge width. This block has no data path, so every pin is a plain control or timing level.

Top module: `vgt_vertical_timing`

## Requirements
- R1: After reset, `vck`, `enb`, `pcg`, `clr` and `vst` are low and `dwn` is high. Nothing moves until the first line strobe arrives.
- R2: Each line strobe makes `vck` change level exactly once. The change is 201 clock edges after the edge that samples the strobe (200 ticks of delay plus one output register).
- R3: `enb` rises 350 to 450 ns after each `vck` edge and stays high for 3450 to 3550 ns.
- R4: `pcg` is high for 1150 to 1250 ns and falls 650 to 750 ns before the `vck` edge of the same line. `pcg` and `enb` are never high together.
- R5: `clr` is high for 3000 to 3200 ns and falls within ±50 ns of the `vck` edge.
- R6: While `clr_en` is low, `clr` stays low, and `enb`, `pcg` and `vck` keep their timing.
- R7: A frame strobe on a cycle without a line strobe arms `vst`. `vst` then rises on the edge that samples the next line strobe and falls on the edge that samples the one after it, so it covers exactly one line including that line's `vck` edge.
- R8: `dwn` takes the value of `dir_down` (1 = down/normal scan, 0 = up/reverse scan) only on the line that raises `vst`. A change of `dir_down` at any other time leaves `dwn` unchanged.
- R9: `vck` alternates level on successive lines, so two lines return it to its starting level.
- R10: A frame strobe in the same cycle as a line strobe raises `vst` for that same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse at the start of each horizontal line |
| frame_stb | input | 1 | One-cycle pulse marking the start of a field |
| dir_down | input | 1 | Vertical direction select, 1 = down, 0 = up |
| clr_en | input | 1 | Enables the uniformity clear pulse |
| vst | output | 1 | Vertical start pulse, one line long |
| vck | output | 1 | Vertical shift clock, toggles once per line |
| enb | output | 1 | Gate-enable pulse |
| pcg | output | 1 | Precharge pulse |
| clr | output | 1 | Uniformity clear pulse |
| dwn | output | 1 | Registered scan direction level |

## Verification
The bench drives isolated lines and measures every edge in clock ticks. It converts those to nanoseconds and compares each width and offset against its allowed window. Running back-to-back lines shows whether the shift clock truly alternates, or is instead pulsed or stuck at a level. A field start sent alone is compared with one that coincides with a line strobe, which separates the armed path from the same-cycle path. A direction change inside a field and a direction change at a field start tell apart direction that is latched from direction that is passed straight through. Dropping the clear enable shows whether gating removes only the clear pulse.

// File: rtl/vgt_pkg.sv
`timescale 1ns/1ps
package vgt_pkg;

  // Round a duration in ns to the nearest whole clock tick.
  function automatic int unsigned ns2tk(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns / 2) / clk_ns;
  endfunction

  // Index of each auxiliary window in the window bank.
  localparam int unsigned WIN_ENB = 0;
  localparam int unsigned WIN_PCG = 1;
  localparam int unsigned WIN_CLR = 2;
  localparam int unsigned WIN_N   = 3;

endpackage

// File: rtl/vgt_phase_cnt.sv
`timescale 1ns/1ps
module vgt_phase_cnt #(
  parameter int unsigned CW      = 9,
  parameter int unsigned EDGE_AT = 200,
  parameter int unsigned IDLE_AT = 395
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  output logic [CW-1:0] phase,
  output logic          vck_o
);
  localparam logic [CW-1:0] EDGE_V = CW'(EDGE_AT);
  localparam logic [CW-1:0] IDLE_V = CW'(IDLE_AT);

  // The counter parks at IDLE_V and restarts from zero on every line strobe.
  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= IDLE_V;
    else if (line_stb)
      phase <= '0;
    else if (phase != IDLE_V)
      phase <= phase + 1'b1;
  end

  // Both levels of the shift clock are shift events, so it toggles once per line.
  always_ff @(posedge clk) begin
    if (!rst_n)
      vck_o <= 1'b0;
    else if (phase == EDGE_V)
      vck_o <= ~vck_o;
  end

  AST_VCK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == IDLE_V && !line_stb) |=> $stable(vck_o)); // R2
endmodule

// File: rtl/vgt_pulse_win.sv
`timescale 1ns/1ps
module vgt_pulse_win #(
  parameter int unsigned CW  = 9,
  parameter int unsigned LO  = 0,
  parameter int unsigned HI  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] phase,
  input  logic          en,
  output logic          pulse_o
);
  localparam logic [CW-1:0] LO_V = CW'(LO);
  localparam logic [CW-1:0] HI_V = CW'(HI);

  // The window is half-open [LO, HI), so the pulse lasts HI-LO ticks.
  always_ff @(posedge clk) begin
    if (!rst_n)
      pulse_o <= 1'b0;
    else
      pulse_o <= en && (phase >= LO_V) && (phase < HI_V);
  end
endmodule

// File: rtl/vgt_start_ctl.sv
`timescale 1ns/1ps
module vgt_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic frame_stb,
  input  logic dir_down,
  output logic vst_o,
  output logic dwn_o
);
  logic armed;
  logic go;

  assign go = line_stb && (armed || frame_stb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      vst_o <= 1'b0;
      dwn_o <= 1'b1;
    end else if (line_stb) begin
      vst_o <= armed || frame_stb;
      armed <= 1'b0;
      if (go)
        dwn_o <= dir_down;
    end else if (frame_stb) begin
      armed <= 1'b1;
    end
  end

  AST_DWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(dwn_o)); // R8
  AST_VST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(vst_o)); // R7
endmodule

// File: rtl/vgt_vertical_timing.sv
`timescale 1ns/1ps
module vgt_vertical_timing #(
  parameter int unsigned CLK_NS     = 20,
  parameter int unsigned VCK_DLY_NS = 4000,
  parameter int unsigned ENB_DLY_NS = 400,
  parameter int unsigned ENB_W_NS   = 3500,
  parameter int unsigned PCG_W_NS   = 1200,
  parameter int unsigned PCG_GAP_NS = 700,
  parameter int unsigned CLR_W_NS   = 3100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic frame_stb,
  input  logic dir_down,
  input  logic clr_en,
  output logic vst,
  output logic vck,
  output logic enb,
  output logic pcg,
  output logic clr,
  output logic dwn
);
  import vgt_pkg::*;

  localparam int unsigned EDGE_AT = ns2tk(VCK_DLY_NS, CLK_NS);
  localparam int unsigned ENB_D   = ns2tk(ENB_DLY_NS, CLK_NS);
  localparam int unsigned ENB_W   = ns2tk(ENB_W_NS, CLK_NS);
  localparam int unsigned PCG_W   = ns2tk(PCG_W_NS, CLK_NS);
  localparam int unsigned PCG_GAP = ns2tk(PCG_GAP_NS, CLK_NS);
  localparam int unsigned CLR_W   = ns2tk(CLR_W_NS, CLK_NS);
  localparam int unsigned IDLE_AT = EDGE_AT + ENB_D + ENB_W;
  localparam int unsigned CW      = $clog2(IDLE_AT + 1);

  localparam int unsigned WIN_LO [WIN_N] = '{EDGE_AT + ENB_D,
                                             EDGE_AT - PCG_GAP - PCG_W,
                                             EDGE_AT - CLR_W};
  localparam int unsigned WIN_HI [WIN_N] = '{EDGE_AT + ENB_D + ENB_W,
                                             EDGE_AT - PCG_GAP,
                                             EDGE_AT};

  logic [CW-1:0]    phase;
  logic [WIN_N-1:0] win_en;
  logic [WIN_N-1:0] win_q;

  assign win_en = {clr_en, 1'b1, 1'b1};

  vgt_phase_cnt #(.CW(CW), .EDGE_AT(EDGE_AT), .IDLE_AT(IDLE_AT)) u_phase (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .phase(phase), .vck_o(vck)
  );

  // One window decoder per auxiliary pulse. All of them share the same
  // register stage as the shift clock, so offsets between them are exact.
  for (genvar k = 0; k < WIN_N; k++) begin : g_win
    vgt_pulse_win #(.CW(CW), .LO(WIN_LO[k]), .HI(WIN_HI[k])) u_win (
      .clk(clk), .rst_n(rst_n), .phase(phase), .en(win_en[k]), .pulse_o(win_q[k])
    );
  end

  assign enb = win_q[WIN_ENB];
  assign pcg = win_q[WIN_PCG];
  assign clr = win_q[WIN_CLR];

  vgt_start_ctl u_start (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
    .dir_down(dir_down), .vst_o(vst), .dwn_o(dwn)
  );

  AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> !clr); // R6
  AST_CLR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clr) && $past(clr_en)) |-> (vck != $past(vck))); // R5
  AST_PCG_ENB_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcg && enb)); // R4
  AST_ENB_QUIET_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vck != $past(vck)) |-> !enb); // R3
endmodule

// File: tb/sim_vgt_vertical_timing.sv
`timescale 1ns/1ps
module sim_vgt_vertical_timing;
  localparam int LINE = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, frame_stb = 1'b0, dir_down = 1'b1, clr_en = 1'b1;
  logic vst, vck, enb, pcg, clr, dwn;

  int checks = 0, errors = 0, cyc = 0, stb_t = 0;
  bit done = 1'b0;
  int vck_t = -1, enb_r = -1, enb_f = -1, pcg_r = -1, pcg_f = -1;
  int clr_r = -1, clr_f = -1, vst_r = -1, vst_f = -1, clr_rises = 0;
  logic p_vck = 1'b0, p_enb = 1'b0, p_pcg = 1'b0, p_clr = 1'b0, p_vst = 1'b0;

  vgt_vertical_timing u0 (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
    .dir_down(dir_down), .clr_en(clr_en), .vst(vst), .vck(vck), .enb(enb),
    .pcg(pcg), .clr(clr), .dwn(dwn)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Edge monitor: records the tick of every transition, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (vck !== p_vck) vck_t = cyc;
      if (enb && !p_enb) enb_r = cyc;
      if (!enb && p_enb) enb_f = cyc;
      if (pcg && !p_pcg) pcg_r = cyc;
      if (!pcg && p_pcg) pcg_f = cyc;
      if (clr && !p_clr) begin clr_r = cyc; clr_rises++; end
      if (!clr && p_clr) clr_f = cyc;
      if (vst && !p_vst) vst_r = cyc;
      if (!vst && p_vst) vst_f = cyc;
    end
    p_vck = vck; p_enb = enb; p_pcg = pcg; p_clr = clr; p_vst = vst;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act_ns, input int lo, input int hi);
    checks++;
    if (act_ns < lo || act_ns > hi) begin
      errors++;
      $display("FAIL %s actual=%0d ns expected=%0d..%0d ns", req, act_ns, lo, hi);
    end
  endtask

  task automatic send_line(input bit with_frame);
    @(negedge clk); line_stb = 1'b1; frame_stb = with_frame;
    @(negedge clk); line_stb = 1'b0; frame_stb = 1'b0; stb_t = cyc;
    repeat (LINE - 2) @(negedge clk);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({vck, enb, pcg, clr, vst} == 5'b0, "R1 outputs low after reset", {vck, enb, pcg, clr, vst}, 0);
    chk(dwn == 1'b1, "R1 dwn high after reset", dwn, 1);
    repeat (600) @(negedge clk);
    chk(vck_t == -1 && enb_r == -1 && pcg_r == -1 && clr_r == -1, "R1 idle without strobe", vck_t, -1);
  endtask

  task automatic t_line_timing();
    logic v0;
    send_line(1'b0);
    v0 = vck;
    chk(vck_t - stb_t == 201, "R2 vck edge offset", vck_t - stb_t, 201);
    chk_win("R3 enb delay", (enb_r - vck_t) * 20, 350, 450);
    chk_win("R3 enb width", (enb_f - enb_r) * 20, 3450, 3550);
    chk_win("R4 pcg width", (pcg_f - pcg_r) * 20, 1150, 1250);
    chk_win("R4 pcg lead", (vck_t - pcg_f) * 20, 650, 750);
    chk(pcg_f <= enb_r, "R4 pcg before enb", pcg_f, enb_r);
    chk_win("R5 clr width", (clr_f - clr_r) * 20, 3000, 3200);
    chk_win("R5 clr fall vs vck", (clr_f - vck_t) * 20, -50, 50);
    send_line(1'b0);
    chk(vck == ~v0, "R9 vck alternates line 2", vck, ~v0);
    chk(vck_t - stb_t == 201, "R2 vck edge offset line 2", vck_t - stb_t, 201);
    send_line(1'b0);
    chk(vck == v0, "R9 vck back after two lines", vck, v0);
  endtask

  task automatic t_clr_off();
    int n0;
    clr_en = 1'b0;
    n0 = clr_rises;
    send_line(1'b0);
    chk(clr_rises == n0, "R6 no clr while disabled", clr_rises - n0, 0);
    chk(vck_t - stb_t == 201, "R6 vck unaffected", vck_t - stb_t, 201);
    chk_win("R6 enb width unaffected", (enb_f - enb_r) * 20, 3450, 3550);
    chk_win("R6 pcg lead unaffected", (vck_t - pcg_f) * 20, 650, 750);
    clr_en = 1'b1;
    send_line(1'b0);
    chk(clr_rises == n0 + 1, "R6 clr returns when enabled", clr_rises - n0, 1);
  endtask

  task automatic t_start();
    pulse_frame();
    chk(vst == 1'b0, "R7 vst waits for line strobe", vst, 0);
    send_line(1'b0);
    chk(vst_r == stb_t, "R7 vst rises with line strobe", vst_r, stb_t);
    chk(vst == 1'b1 && vck_t > vst_r, "R7 vst held across vck edge", vst, 1);
    send_line(1'b0);
    chk(vst_f == stb_t, "R7 vst falls at next line strobe", vst_f, stb_t);
    send_line(1'b0);
    chk(vst == 1'b0, "R7 vst only one line", vst, 0);
  endtask

  task automatic t_coincident();
    send_line(1'b1);
    chk(vst_r == stb_t && vst == 1'b1, "R10 same-cycle frame strobe", vst_r, stb_t);
    send_line(1'b0);
    chk(vst == 1'b0, "R10 vst one line", vst, 0);
  endtask

  task automatic t_direction();
    dir_down = 1'b0;
    pulse_frame();
    send_line(1'b0);
    chk(dwn == 1'b0, "R8 up scan latched at field start", dwn, 0);
    dir_down = 1'b1;
    send_line(1'b0);
    chk(dwn == 1'b0, "R8 mid-field change ignored", dwn, 0);
    send_line(1'b1);
    chk(dwn == 1'b1, "R8 down scan latched at next field", dwn, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_line_timing();
    t_clr_off();
    t_start();
    t_coincident();
    t_direction();
    finish_run();
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule